// File: doc/BRIEF.md
# SPI Slave Hold-Condition Controller

This block sits in front of the serial shifter of an SPI slave and decides when a serial transfer is paused and when it continues. It samples the chip-select, the serial clock and a dual-purpose pin with a faster system clock. When the pin is in its pause role, the block freezes the shifter by dropping a shift-enable and turns the serial output driver off. The bit counter and shift register of the shifter stay as they are, so the transfer picks up again at the same bit.

After power-up the dual-purpose pin is an active-low device reset, and the block passes it on as a reset request. A single-cycle pulse from the command decoder switches the pin to its pause role. The pin keeps that role until the system power-on reset is applied again. In the pause role, a pause starts or ends only while the serial clock is low. A pin edge that arrives while the clock is high takes effect when the clock next goes low. Raising chip-select ends any pause and puts the slave in standby.

Top module: `spi_hold_gate`

## Requirements
- R1: After power-on reset the pin has its reset role: `dev_reset_o` is 1 while the pin is low and 0 while it is high, and `hold_active_o` stays 0 whatever the pin does.
- R2: One cycle with `hold_cmd_i` = 1 gives the pin its pause role. From then on `dev_reset_o` is 0 at every pin level.
- R3: The pause role is kept across further command pulses, chip-select toggles and any pin activity. Only `rst_n` brings back the reset role.
- R4: In the pause role, with chip-select low, a falling pin edge while the serial clock is low sets `hold_active_o` to 1.
- R5: A falling pin edge while the serial clock is high leaves `hold_active_o` at 0 until the clock goes low, and then sets it. If the pin rises again before the clock goes low, no pause occurs.
- R6: During a pause, a rising pin edge while the clock is low clears `hold_active_o`. A rising edge while the clock is high keeps the pause until the clock next goes low. If the pin falls again before that, the pause continues.
- R7: While the pin stays low, the pause continues through any number of serial clock edges.
- R8: Chip-select going high during a pause (armed or active) clears `hold_active_o`, and the slave is in standby: `shift_en_o` = 0 and `so_oe_n_o` = 1.
- R9: `shift_en_o` is 1 exactly when chip-select is low and no pause is active. `so_oe_n_o` (1 = output high-impedance) is 1 when chip-select is high or a pause is active.
- R10: A pause needs a pin edge with chip-select low. A fall of the pin while chip-select is high does not cause a pause when chip-select later goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, faster than the serial clock |
| rst_n | input | 1 | Power-on reset, active low; gives the pin back its reset role |
| sck_i | input | 1 | Serial clock from the bus master (asynchronous) |
| cs_n_i | input | 1 | Chip-select, active low (asynchronous) |
| pin_n_i | input | 1 | Dual-purpose reset / pause pin, active low (asynchronous) |
| hold_cmd_i | input | 1 | Single-cycle pulse from the decoder: switch the pin to its pause role |
| hold_active_o | output | 1 | Pause in effect |
| shift_en_o | output | 1 | Shifter may shift and count on serial clock edges |
| so_oe_n_o | output | 1 | Serial output driver disabled (high-impedance) when 1 |
| dev_reset_o | output | 1 | Device reset request while the pin has its reset role and is low |

## Verification
The bench aims at the clock-phase qualification. A pin edge with the serial clock high must wait for the clock-low phase. A design that acts on the edge at once would pause or resume half a bit early, and one that waits for the next edge instead of the clock level would miss the exit. Pin glitches that reverse before the clock goes low are driven to expose a design that latches the first edge and leaves the shifter frozen. Chip-select deselection during an armed or active pause checks that standby wins, and further command pulses and a later power-on reset check that the pin role is neither lost early nor kept after reset.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

   // Pause sequencer states
   typedef enum logic [1:0] {
      HS_RUN     = 2'd0,   // shifting normally
      HS_ARM_IN  = 2'd1,   // pin fell with clock high, waiting for clock low
      HS_FROZEN  = 2'd2,   // pause in effect
      HS_ARM_OUT = 2'd3    // pin rose with clock high, waiting for clock low
   } hold_state_e;

   // Role of the dual-purpose pin
   typedef enum logic {
      ROLE_RESET = 1'b0,
      ROLE_PAUSE = 1'b1
   } pin_role_e;

endpackage

// File: rtl/shg_sync.sv
module shg_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("shg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[LAST];

endmodule

// File: rtl/shg_pin_role.sv
module shg_pin_role
   import spi_hold_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      hold_cmd_i,
   output pin_role_e role_o
);

   pin_role_e role_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          role_q <= ROLE_RESET;
      else if (hold_cmd_i) role_q <= ROLE_PAUSE;
   end

   assign role_o = role_q;

   AST_CMD_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      hold_cmd_i |=> (role_q == ROLE_PAUSE)); // R2

   AST_ROLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (role_q == ROLE_PAUSE) |=> (role_q == ROLE_PAUSE)); // R3

endmodule

// File: rtl/shg_hold_fsm.sv
module shg_hold_fsm
   import spi_hold_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sck_s,
   input  logic      cs_n_s,
   input  logic      pin_s,
   input  pin_role_e role_i,
   output logic      hold_active_o
);

   hold_state_e st_q, st_d;
   logic        pin_q;
   logic        pin_fell, pin_rose;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b1;
      else        pin_q <= pin_s;
   end

   assign pin_fell = pin_q & ~pin_s;
   assign pin_rose = ~pin_q & pin_s;

   always_comb begin
      st_d = st_q;
      if (cs_n_s || (role_i != ROLE_PAUSE)) begin
         st_d = HS_RUN;
      end else begin
         unique case (st_q)
            HS_RUN: begin
               if (pin_fell) st_d = sck_s ? HS_ARM_IN : HS_FROZEN;
            end
            HS_ARM_IN: begin
               if (pin_s)       st_d = HS_RUN;
               else if (!sck_s) st_d = HS_FROZEN;
            end
            HS_FROZEN: begin
               if (pin_rose) st_d = sck_s ? HS_ARM_OUT : HS_RUN;
            end
            HS_ARM_OUT: begin
               if (!pin_s)      st_d = HS_FROZEN;
               else if (!sck_s) st_d = HS_RUN;
            end
            default: st_d = HS_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= HS_RUN;
      else        st_q <= st_d;
   end

   assign hold_active_o = (st_q == HS_FROZEN) || (st_q == HS_ARM_OUT);

   AST_NO_PAUSE_IN_RESET_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
      (role_i == ROLE_RESET) |=> !hold_active_o); // R1

   AST_ENTER_ON_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_active_o) |-> $past(!sck_s)); // R5

   AST_EXIT_ON_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_active_o) |-> ($past(!sck_s) || $past(cs_n_s))); // R6

   AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !hold_active_o); // R8

   AST_PIN_LOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_active_o && !cs_n_s && !pin_s && !pin_q) |=> hold_active_o); // R7

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
   import spi_hold_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_n_i,
   input  logic pin_n_i,
   input  logic hold_cmd_i,
   output logic hold_active_o,
   output logic shift_en_o,
   output logic so_oe_n_o,
   output logic dev_reset_o
);

   localparam int unsigned NSIG = 3;
   localparam logic [NSIG-1:0] SYNC_RST = 3'b110; // pin high, cs high, sck low

   logic [NSIG-1:0] raw, synced;
   logic            sck_s, cs_n_s, pin_s;
   pin_role_e       role;
   logic            hold_act;

   assign raw = {pin_n_i, cs_n_i, sck_i};

   shg_sync #(
      .WIDTH  (NSIG),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(raw),
      .sync_o (synced)
   );

   assign sck_s  = synced[0];
   assign cs_n_s = synced[1];
   assign pin_s  = synced[2];

   shg_pin_role u_role (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_cmd_i(hold_cmd_i),
      .role_o    (role)
   );

   shg_hold_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .sck_s        (sck_s),
      .cs_n_s       (cs_n_s),
      .pin_s        (pin_s),
      .role_i       (role),
      .hold_active_o(hold_act)
   );

   assign hold_active_o = hold_act;
   assign shift_en_o    = ~cs_n_s & ~hold_act;
   assign so_oe_n_o     = cs_n_s | hold_act;
   assign dev_reset_o   = (role == ROLE_RESET) & ~pin_s;

   AST_PAUSE_BLOCKS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active_o |-> (!shift_en_o && so_oe_n_o)); // R9

   AST_NO_RESET_IN_PAUSE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold_cmd_i) |-> !dev_reset_o); // R2

endmodule

// File: tb/spi_hold_gate_tb_top.sv
module spi_hold_gate_tb_top;

   localparam int SETTLE = 6;

   logic clk = 1'b0;
   logic rst_n;
   logic sck, cs_n, pin_n, cmd;
   logic hold_active, shift_en, so_oe_n, dev_reset;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference model: st 0 run, 1 armed-in, 2 frozen, 3 armed-out
   bit m_role;
   int m_st;

   always #2 clk = ~clk;

   spi_hold_gate #(.SYNC_STAGES(2)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .sck_i        (sck),
      .cs_n_i       (cs_n),
      .pin_n_i      (pin_n),
      .hold_cmd_i   (cmd),
      .hold_active_o(hold_active),
      .shift_en_o   (shift_en),
      .so_oe_n_o    (so_oe_n),
      .dev_reset_o  (dev_reset)
   );

   function automatic bit exp_hold(int st);
      return (st == 2) || (st == 3);
   endfunction

   function automatic int next_on_pin(int st, bit sck_lvl, bit new_pin);
      if (st == 0 && !new_pin) return sck_lvl ? 1 : 2;
      if (st == 1 &&  new_pin) return 0;
      if (st == 2 &&  new_pin) return sck_lvl ? 3 : 0;
      if (st == 3 && !new_pin) return 2;
      return st;
   endfunction

   function automatic int next_on_sck(int st, bit new_sck);
      if (!new_sck && st == 1) return 2;
      if (!new_sck && st == 3) return 0;
      return st;
   endfunction

   task automatic check(string tag);
      bit eh, es, eo, er;
      eh = exp_hold(m_st);
      es = !cs_n && !eh;
      eo = cs_n || eh;
      er = !m_role && !pin_n;
      n_tests++;
      if (hold_active !== eh || shift_en !== es || so_oe_n !== eo || dev_reset !== er) begin
         n_fail++;
         $display("FAIL %s: got hold=%b shen=%b oen=%b rst=%b exp hold=%b shen=%b oen=%b rst=%b",
                  tag, hold_active, shift_en, so_oe_n, dev_reset, eh, es, eo, er);
      end
   endtask

   task automatic settle();
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic set_sck(bit v, string tag);
      sck = v;
      if (m_role && !cs_n) m_st = next_on_sck(m_st, v);
      settle(); check(tag);
   endtask

   task automatic set_pin(bit v, string tag);
      pin_n = v;
      if (m_role && !cs_n) m_st = next_on_pin(m_st, sck, v);
      settle(); check(tag);
   endtask

   task automatic set_cs(bit v, string tag);
      cs_n = v;
      if (v) m_st = 0;
      settle(); check(tag);
   endtask

   task automatic pulse_cmd(string tag);
      cmd = 1'b1;
      @(negedge clk);
      cmd = 1'b0;
      m_role = 1'b1;
      settle(); check(tag);
   endtask

   task automatic do_reset(string tag);
      rst_n = 1'b0;
      m_role = 1'b0;
      m_st = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle(); check(tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; pin_n = 1'b1; cmd = 1'b0;
      do_reset("R1");
      check("R9");

      // reset role: pin low means device reset, no pause
      set_cs(1'b0, "R9");
      set_pin(1'b0, "R1");
      set_sck(1'b1, "R1");
      set_sck(1'b0, "R1");
      set_pin(1'b1, "R1");

      // switch role
      set_pin(1'b0, "R2");
      pulse_cmd("R2");
      set_pin(1'b1, "R2");

      // falling edge with clock low
      set_pin(1'b0, "R4");
      set_sck(1'b1, "R7");
      set_sck(1'b0, "R7");
      set_sck(1'b1, "R7");
      // rising with clock high: deferred
      set_pin(1'b1, "R6");
      set_sck(1'b0, "R6");

      // falling with clock high: deferred
      set_sck(1'b1, "R5");
      set_pin(1'b0, "R5");
      set_sck(1'b0, "R5");
      // rising with clock low: immediate exit
      set_pin(1'b1, "R6");

      // glitch in armed-in state
      set_sck(1'b1, "R5");
      set_pin(1'b0, "R5");
      set_pin(1'b1, "R5");
      set_sck(1'b0, "R5");

      // glitch in armed-out state
      set_pin(1'b0, "R4");
      set_sck(1'b1, "R6");
      set_pin(1'b1, "R6");
      set_pin(1'b0, "R6");
      set_sck(1'b0, "R6");
      set_sck(1'b1, "R7");

      // deselect during pause, then during armed-in
      set_cs(1'b1, "R8");
      set_pin(1'b1, "R8");
      set_cs(1'b0, "R9");
      set_sck(1'b1, "R8");
      set_pin(1'b0, "R8");
      set_cs(1'b1, "R8");
      set_sck(1'b0, "R8");

      // pin fell while deselected: no pause on select
      set_cs(1'b0, "R10");
      set_sck(1'b1, "R10");
      set_sck(1'b0, "R10");
      set_pin(1'b1, "R10");

      // role sticky through another command
      pulse_cmd("R3");

      // random phase
      for (int i = 0; i < 600; i++) begin
         int pick;
         pick = int'($urandom_range(0, 99));
         if (pick < 45)      set_sck(~sck, "R9");
         else if (pick < 78) set_pin(~pin_n, "R7");
         else if (pick < 96) set_cs(~cs_n, "R8");
         else                pulse_cmd("R3");
      end

      // power-on reset returns the reset role
      set_cs(1'b1, "R3");
      set_pin(1'b1, "R3");
      set_sck(1'b0, "R3");
      do_reset("R3");
      set_pin(1'b0, "R3");
      set_cs(1'b0, "R1");
      set_pin(1'b1, "R1");
      set_pin(1'b0, "R1");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule